// File: doc/BRIEF.md
# Trap Entry and Return Unit

This block carries out the control-state changes that a register-window processor makes when it takes a trap or retires a trap-return instruction. Each cycle it looks at three event sources. The first is a hardware trap request, which carries its own 8-bit trap type. The second is a software trap instruction, which carries two operands. The third is a return strobe, which also carries two operands. The block picks at most one of these events, and all of that event's effects land together on the next rising clock edge.

On trap entry the block computes a vector address from the trap base register and the trap type. It updates the status bits: trap enable, supervisor, saved supervisor and current window. It writes the interrupted PC and next-PC into the first two local registers of the window it has just entered. It also redirects fetch and clears any pending annul. On return it restores the supervisor bit, enables traps again, steps the window back and redirects fetch to the sum of the two operands.

If a software trap arrives while traps are disabled, the block does not vector. Instead it enters a sticky error mode.

Top module: `trap_seq_unit`

## Requirements
- R1: On trap entry, `redir_pc` equals {`tbr_q`[31:12] as held before the edge, trap type, 4'h0}, and `redir_npc` equals `redir_pc` + 4. For a hardware trap the trap type is `hw_tt`.
- R2: On trap entry, `st_et` becomes 0, `st_ps` takes the old `st_s`, and `st_s` becomes 1.
- R3: On trap entry, `st_cwp` becomes `st_cwp`+1 modulo NWIN, so NWIN-1 wraps to 0.
- R4: On trap entry, `save_we` pulses for one cycle. At the same time `save_win` carries the new window, `save_l1` carries the old `cur_pc` and `save_l2` carries the old `cur_npc`.
- R5: Every event's effects appear in the cycle after it is sampled. `redir_valid` pulses for one cycle on trap entry and on return, and `annul_clr` pulses only on trap entry.
- R6: A software trap uses trap type 128 + ((`sw_op_a` + `sw_op_b`) mod 128).
- R7: A software trap sampled while `st_et` is 0 sets `err_mode`. It causes no redirect, no save and no status change.
- R8: Trap entry writes the trap type into `tbr_q`[11:4]. `base_wr` changes only `tbr_q`[31:12], taken from `base_wdata`. `tbr_q`[3:0] is always 0, and both writes may happen on the same edge.
- R9: On return, `st_s` takes `st_ps` and `st_et` becomes 1. `st_cwp` steps back modulo NWIN, so 0 wraps to NWIN-1. `redir_pc` becomes `ret_op_a`+`ret_op_b` and `redir_npc` becomes that sum + 4.
- R10: Priority is hardware request first, then software trap, then return. Only the winning event has any effect.
- R11: Once `err_mode` is set, it stays set until reset, and all trap and return requests are ignored. Base register writes still apply.
- R12: Reset gives `st_et`=1, `st_s`=1, `st_ps`=0, `st_cwp`=0 and `tbr_q`=0, with all pulse outputs and all data outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware trap request |
| hw_tt | input | 8 | Hardware trap type |
| sw_req | input | 1 | Software trap instruction |
| sw_op_a | input | 32 | Software trap operand A |
| sw_op_b | input | 32 | Software trap operand B |
| ret_req | input | 1 | Trap-return instruction |
| ret_op_a | input | 32 | Return operand A |
| ret_op_b | input | 32 | Return operand B |
| cur_pc | input | 32 | PC of the current instruction |
| cur_npc | input | 32 | Next-PC of the current instruction |
| base_wr | input | 1 | Software write to the base register |
| base_wdata | input | 32 | Base register write data (bits 31:12 used) |
| st_et | output | 1 | Trap enable |
| st_s | output | 1 | Supervisor |
| st_ps | output | 1 | Saved supervisor |
| st_cwp | output | CWPW | Current window |
| tbr_q | output | 32 | Trap base register |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | 32 | Redirect PC |
| redir_npc | output | 32 | Redirect next-PC |
| save_we | output | 1 | Local register save pulse |
| save_win | output | CWPW | Window of the save |
| save_l1 | output | 32 | Value for local register 1 |
| save_l2 | output | 32 | Value for local register 2 |
| annul_clr | output | 1 | Clear pending annul |
| err_mode | output | 1 | Error mode flag |

## Verification
The assertions assume that every request input is low while reset is held. Their past-value checks then refer only to events that are really sampled after reset. They also assume that the inputs settle to known values before each rising edge. The bench drives all inputs on the falling edge and keeps every request low throughout each reset. It also re-applies reset whenever a random run has fallen into error mode, so that the trap and return paths keep being exercised.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {EV_NONE, EV_HW, EV_SW, EV_ERR, EV_RET} ev_kind_t;

  // Vector address: base upper bits, trap type, zero nibble
  function automatic logic [31:0] vec_of(logic [31:0] base, logic [7:0] tt);
    return {base[31:12], tt, 4'h0};
  endfunction

  // Software trap numbers live in the upper half of the type space
  function automatic logic [7:0] sw_type(logic [31:0] a, logic [31:0] b);
    logic [31:0] sum;
    sum = a + b;
    return {1'b1, sum[6:0]};
  endfunction

  function automatic int unsigned win_fwd(int unsigned w, int unsigned n);
    return (w + 1 == n) ? 0 : w + 1;
  endfunction

  function automatic int unsigned win_back(int unsigned w, int unsigned n);
    return (w == 0) ? n - 1 : w - 1;
  endfunction

endpackage

// File: rtl/trap_arb.sv
module trap_arb
  import trap_pkg::*;
(
  input  logic        hw_req,
  input  logic [7:0]  hw_tt,
  input  logic        sw_req,
  input  logic [31:0] sw_a,
  input  logic [31:0] sw_b,
  input  logic        ret_req,
  input  logic        et,
  input  logic        err_mode,
  output ev_kind_t    kind,
  output logic [7:0]  tt_sel
);

  always_comb begin
    kind   = EV_NONE;
    tt_sel = 8'h00;
    if (!err_mode) begin
      if (hw_req) begin
        kind   = EV_HW;
        tt_sel = hw_tt;
      end else if (sw_req) begin
        if (et) begin
          kind   = EV_SW;
          tt_sel = sw_type(sw_a, sw_b);
        end else begin
          kind = EV_ERR;
        end
      end else if (ret_req) begin
        kind = EV_RET;
      end
    end
  end

endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_trap,
  input  logic            take_ret,
  input  logic            take_err,
  output logic            et,
  output logic            s,
  output logic            ps,
  output logic [CWPW-1:0] cwp,
  output logic [CWPW-1:0] cwp_fwd,
  output logic            err_mode
);

  logic [CWPW-1:0] cwp_back;

  assign cwp_fwd  = CWPW'(win_fwd(32'(cwp), NWIN));
  assign cwp_back = CWPW'(win_back(32'(cwp), NWIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      et       <= 1'b1;
      s        <= 1'b1;
      ps       <= 1'b0;
      cwp      <= '0;
      err_mode <= 1'b0;
    end else if (take_trap) begin
      et  <= 1'b0;
      ps  <= s;
      s   <= 1'b1;
      cwp <= cwp_fwd;
    end else if (take_ret) begin
      s   <= ps;
      et  <= 1'b1;
      cwp <= cwp_back;
    end else if (take_err) begin
      err_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/trap_seq_unit.sv
module trap_seq_unit
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_req,
  input  logic [7:0]      hw_tt,
  input  logic            sw_req,
  input  logic [31:0]     sw_op_a,
  input  logic [31:0]     sw_op_b,
  input  logic            ret_req,
  input  logic [31:0]     ret_op_a,
  input  logic [31:0]     ret_op_b,
  input  logic [31:0]     cur_pc,
  input  logic [31:0]     cur_npc,
  input  logic            base_wr,
  input  logic [31:0]     base_wdata,
  output logic            st_et,
  output logic            st_s,
  output logic            st_ps,
  output logic [CWPW-1:0] st_cwp,
  output logic [31:0]     tbr_q,
  output logic            redir_valid,
  output logic [31:0]     redir_pc,
  output logic [31:0]     redir_npc,
  output logic            save_we,
  output logic [CWPW-1:0] save_win,
  output logic [31:0]     save_l1,
  output logic [31:0]     save_l2,
  output logic            annul_clr,
  output logic            err_mode
);

  ev_kind_t        ev_kind;
  logic [7:0]      ev_tt;
  logic            take_trap;
  logic            take_ret;
  logic            take_err;
  logic [CWPW-1:0] cwp_fwd;
  logic [31:0]     vec_addr;
  logic [31:0]     ret_tgt;

  trap_arb arb_i (
    .hw_req   (hw_req),
    .hw_tt    (hw_tt),
    .sw_req   (sw_req),
    .sw_a     (sw_op_a),
    .sw_b     (sw_op_b),
    .ret_req  (ret_req),
    .et       (st_et),
    .err_mode (err_mode),
    .kind     (ev_kind),
    .tt_sel   (ev_tt)
  );

  assign take_trap = (ev_kind == EV_HW) || (ev_kind == EV_SW);
  assign take_ret  = (ev_kind == EV_RET);
  assign take_err  = (ev_kind == EV_ERR);

  trap_status #(.NWIN(NWIN), .CWPW(CWPW)) status_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_trap (take_trap),
    .take_ret  (take_ret),
    .take_err  (take_err),
    .et        (st_et),
    .s         (st_s),
    .ps        (st_ps),
    .cwp       (st_cwp),
    .cwp_fwd   (cwp_fwd),
    .err_mode  (err_mode)
  );

  assign vec_addr = vec_of(tbr_q, ev_tt);
  assign ret_tgt  = ret_op_a + ret_op_b;

  // Base register: software owns the upper field, trap entry owns the type field
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbr_q <= '0;
    end else begin
      if (base_wr)   tbr_q[31:12] <= base_wdata[31:12];
      if (take_trap) tbr_q[11:4]  <= ev_tt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      save_we     <= 1'b0;
      save_win    <= '0;
      save_l1     <= '0;
      save_l2     <= '0;
      annul_clr   <= 1'b0;
    end else begin
      redir_valid <= 1'b0;
      save_we     <= 1'b0;
      annul_clr   <= 1'b0;
      if (take_trap) begin
        redir_valid <= 1'b1;
        redir_pc    <= vec_addr;
        redir_npc   <= vec_addr + 32'd4;
        save_we     <= 1'b1;
        save_win    <= cwp_fwd;
        save_l1     <= cur_pc;
        save_l2     <= cur_npc;
        annul_clr   <= 1'b1;
      end else if (take_ret) begin
        redir_valid <= 1'b1;
        redir_pc    <= ret_tgt;
        redir_npc   <= ret_tgt + 32'd4;
      end
    end
  end

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int NWIN = 8,
  parameter int CWPW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_req,
  input logic [7:0]      hw_tt,
  input logic            sw_req,
  input logic [31:0]     ret_op_a,
  input logic [31:0]     ret_op_b,
  input logic [31:0]     cur_pc,
  input logic [31:0]     cur_npc,
  input logic            base_wr,
  input logic            st_et,
  input logic            st_s,
  input logic            st_ps,
  input logic [CWPW-1:0] st_cwp,
  input logic [31:0]     tbr_q,
  input logic            redir_valid,
  input logic [31:0]     redir_pc,
  input logic [31:0]     redir_npc,
  input logic            save_we,
  input logic [CWPW-1:0] save_win,
  input logic [31:0]     save_l1,
  input logic [31:0]     save_l2,
  input logic            annul_clr,
  input logic            err_mode,
  input logic            take_trap,
  input logic            take_ret,
  input logic            take_err,
  input logic [7:0]      ev_tt
);

  // R1
  entry_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> redir_pc == {$past(tbr_q[31:12]), $past(ev_tt), 4'h0}
                  && redir_npc == redir_pc + 32'd4);

  // R2
  entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> !st_et && st_s && (st_ps == $past(st_s)));

  // R3
  entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> st_cwp == (($past(st_cwp) == CWPW'(NWIN - 1)) ? '0 : $past(st_cwp) + 1'b1));

  // R4
  save_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> save_we && save_win == st_cwp
                  && save_l1 == $past(cur_pc) && save_l2 == $past(cur_npc));

  // R5
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> redir_valid && !annul_clr && !save_we);

  // R7
  err_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_err |=> err_mode && !redir_valid && !save_we && !st_et);

  // R8
  tbr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && !take_trap) |=> tbr_q[11:0] == $past(tbr_q[11:0]));

  // R9
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> st_et && (st_s == $past(st_ps))
                 && redir_pc == $past(ret_op_a) + $past(ret_op_b));

  // R10
  priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && sw_req && !err_mode) |=> redir_valid && redir_pc[11:4] == $past(hw_tt));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode && !redir_valid && !save_we);

endmodule

bind trap_seq_unit trap_seq_chk #(.NWIN(NWIN), .CWPW(CWPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_tt(hw_tt), .sw_req(sw_req),
  .ret_op_a(ret_op_a), .ret_op_b(ret_op_b), .cur_pc(cur_pc), .cur_npc(cur_npc),
  .base_wr(base_wr), .st_et(st_et), .st_s(st_s), .st_ps(st_ps), .st_cwp(st_cwp),
  .tbr_q(tbr_q), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .redir_npc(redir_npc), .save_we(save_we), .save_win(save_win),
  .save_l1(save_l1), .save_l2(save_l2), .annul_clr(annul_clr),
  .err_mode(err_mode), .take_trap(take_trap), .take_ret(take_ret),
  .take_err(take_err), .ev_tt(ev_tt)
);

// File: tb/trap_seq_unit_tb_top.sv
`timescale 1ns/1ps
module trap_seq_unit_tb_top;
  localparam int NWIN = 8;
  localparam int CWPW = $clog2(NWIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_req = 0, sw_req = 0, ret_req = 0, base_wr = 0;
  logic [7:0]  hw_tt = '0;
  logic [31:0] sw_op_a = '0, sw_op_b = '0, ret_op_a = '0, ret_op_b = '0;
  logic [31:0] cur_pc = '0, cur_npc = '0, base_wdata = '0;

  logic st_et, st_s, st_ps, redir_valid, save_we, annul_clr, err_mode;
  logic [CWPW-1:0] st_cwp, save_win;
  logic [31:0] tbr_q, redir_pc, redir_npc, save_l1, save_l2;

  always #2.5 clk = ~clk;

  trap_seq_unit #(.NWIN(NWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_tt(hw_tt), .sw_req(sw_req),
    .sw_op_a(sw_op_a), .sw_op_b(sw_op_b), .ret_req(ret_req), .ret_op_a(ret_op_a),
    .ret_op_b(ret_op_b), .cur_pc(cur_pc), .cur_npc(cur_npc), .base_wr(base_wr),
    .base_wdata(base_wdata), .st_et(st_et), .st_s(st_s), .st_ps(st_ps),
    .st_cwp(st_cwp), .tbr_q(tbr_q), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .redir_npc(redir_npc), .save_we(save_we),
    .save_win(save_win), .save_l1(save_l1), .save_l2(save_l2),
    .annul_clr(annul_clr), .err_mode(err_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string ctx = "R12 reset";

  // reference state
  bit m_et, m_s, m_ps, m_err;
  int m_cwp;
  bit [31:0] m_tbr;
  bit e_rv, e_we, e_ann;
  bit [31:0] e_rpc, e_rnpc, e_l1, e_l2;
  int e_win;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] got=%h exp=%h at %0t", tag, ctx, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 redir_pc", redir_pc, e_rpc);
    chk("R1 redir_npc", redir_npc, e_rnpc);
    chk("R5 redir_valid", 32'(redir_valid), 32'(e_rv));
    chk("R5 annul_clr", 32'(annul_clr), 32'(e_ann));
    chk("R4 save_we", 32'(save_we), 32'(e_we));
    chk("R4 save_win", 32'(save_win), e_win);
    chk("R4 save_l1", save_l1, e_l1);
    chk("R4 save_l2", save_l2, e_l2);
    chk("R2 st_et", 32'(st_et), 32'(m_et));
    chk("R2 st_s", 32'(st_s), 32'(m_s));
    chk("R2 st_ps", 32'(st_ps), 32'(m_ps));
    chk("R3 st_cwp", 32'(st_cwp), m_cwp);
    chk("R8 tbr_q", tbr_q, m_tbr);
    chk("R7 err_mode", 32'(err_mode), 32'(m_err));
  endtask

  task automatic model_reset();
    m_et = 1; m_s = 1; m_ps = 0; m_err = 0; m_cwp = 0; m_tbr = 0;
    e_rv = 0; e_we = 0; e_ann = 0; e_rpc = 0; e_rnpc = 0; e_l1 = 0; e_l2 = 0; e_win = 0;
  endtask

  task automatic clear_in();
    hw_req = 0; sw_req = 0; ret_req = 0; base_wr = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    ctx = "R12 reset";
    compare_all();
  endtask

  // Advance the reference by one edge from the present inputs, then compare.
  task automatic step();
    int kind;
    int tt;
    bit [31:0] nt, tgt;
    kind = 0; tt = 0;
    e_rv = 0; e_we = 0; e_ann = 0;
    if (!m_err) begin
      if (hw_req) begin kind = 1; tt = int'(hw_tt); end
      else if (sw_req) begin
        if (m_et) begin kind = 1; tt = 128 + int'((sw_op_a + sw_op_b) % 128); end
        else kind = 2;
      end else if (ret_req) kind = 3;
    end
    nt = m_tbr;
    if (base_wr) nt = (base_wdata & 32'hFFFF_F000) | (m_tbr & 32'h0000_0FFF);
    if (kind == 1) begin
      e_rpc = (m_tbr & 32'hFFFF_F000) + 32'(tt * 16);
      e_rnpc = e_rpc + 4;
      e_rv = 1; e_ann = 1; e_we = 1;
      m_ps = m_s; m_s = 1; m_et = 0;
      m_cwp = (m_cwp + 1) % NWIN;
      e_win = m_cwp; e_l1 = cur_pc; e_l2 = cur_npc;
      nt = (nt & 32'hFFFF_F00F) | 32'(tt * 16);
    end else if (kind == 2) begin
      m_err = 1;
    end else if (kind == 3) begin
      tgt = ret_op_a + ret_op_b;
      e_rv = 1; e_rpc = tgt; e_rnpc = tgt + 4;
      m_s = m_ps; m_et = 1;
      m_cwp = (m_cwp + NWIN - 1) % NWIN;
    end
    m_tbr = nt;
    @(negedge clk);
    compare_all();
    clear_in();
  endtask

  task automatic hw(input logic [7:0] t, input logic [31:0] pc);
    hw_req = 1; hw_tt = t; cur_pc = pc; cur_npc = pc + 4; step();
  endtask
  task automatic sw(input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
    sw_req = 1; sw_op_a = a; sw_op_b = b; cur_pc = pc; cur_npc = pc + 4; step();
  endtask
  task automatic rt(input logic [31:0] a, input logic [31:0] b);
    ret_req = 1; ret_op_a = a; ret_op_b = b; step();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    do_reset();

    ctx = "R8 base write keeps low field";
    base_wr = 1; base_wdata = 32'hABCD_E5F7; step();
    step();

    ctx = "R1 hardware vector";
    hw(8'h05, 32'h0000_1000);
    ctx = "R9 return";
    rt(32'h0000_1000, 32'h0000_0004);

    ctx = "R3 window wrap forward";
    for (int i = 0; i < NWIN + 1; i++) hw(8'(8'h10 + i), 32'h2000 + 32'(i * 8));
    ctx = "R9 window wrap back";
    for (int i = 0; i < NWIN + 2; i++) rt(32'h4000, 32'(i * 4));

    ctx = "R6 software type 0x7F+3";
    sw(32'h0000_007F, 32'h0000_0003, 32'h3000);
    rt(32'h3000, 32'h8);
    ctx = "R6 software type wrapped sum";
    sw(32'hFFFF_FFFF, 32'h0000_0001, 32'h3100);
    rt(32'h3100, 32'h8);

    ctx = "R10 hw over sw";
    hw_req = 1; hw_tt = 8'h2A; sw_req = 1; sw_op_a = 5; sw_op_b = 6; cur_pc = 32'h5000; step();
    rt(32'h5000, 0);
    ctx = "R10 sw over ret";
    sw_req = 1; sw_op_a = 1; sw_op_b = 2; ret_req = 1; ret_op_a = 32'h9999; cur_pc = 32'h5100; step();
    ctx = "R10 hw over ret";
    hw_req = 1; hw_tt = 8'h07; ret_req = 1; ret_op_a = 32'h7777; step();

    ctx = "R8 base write with trap";
    hw_req = 1; hw_tt = 8'h3C; base_wr = 1; base_wdata = 32'h1234_5FFF; step();

    ctx = "R7 software trap with traps off";
    sw(32'h10, 32'h20, 32'h6000);
    step();
    ctx = "R11 events ignored in error mode";
    hw(8'h01, 32'h6100);
    rt(32'h1, 32'h2);
    sw(32'h1, 32'h2, 32'h6200);
    base_wr = 1; base_wdata = 32'hCAFE_0000; step();
    step();

    do_reset();
    ctx = "R10 random mix";
    for (int i = 0; i < 400; i++) begin
      hw_req  = ($urandom_range(0, 5) == 0);
      sw_req  = ($urandom_range(0, 4) == 0);
      ret_req = ($urandom_range(0, 2) == 0);
      base_wr = ($urandom_range(0, 7) == 0);
      hw_tt = 8'($urandom); sw_op_a = $urandom; sw_op_b = $urandom;
      ret_op_a = $urandom; ret_op_b = $urandom; base_wdata = $urandom;
      cur_pc = $urandom; cur_npc = $urandom;
      step();
      if (m_err) begin
        do_reset();
        ctx = "R10 random mix";
      end
    end

    finish_run();
  end
endmodule